// File: doc/BRIEF.md
# ADC Result Buffer Controller

This block sits behind an analog-to-digital conversion engine. It collects the 12-bit samples that the engine delivers into a 16-word result memory. It counts the samples against a programmable samples-per-interrupt setting. When a sequence is complete, it raises a done flag and an interrupt flag. Software reads the stored words through an indexed read port. Software cannot write the memory: only accepted conversions change its contents.

The block has two fill modes. In the linear mode, every sequence writes from word 0 upward, and software must empty the memory before the next sequence overwrites it. In the split mode, the memory behaves as two 8-word halves that swap on every interrupt. An output bit reports which half is currently being filled, so software has a whole sequence period to read the other half. Dropping the enable input returns the fill position to word 0 of the lower half and blocks all writes.

Top module: `adc_result_buffer`

## Requirements
- R1: After reset, done, irq and fill_half are 0 and every word of the result memory reads 0.
- R2: In linear mode (split_mode=0), the k-th conversion of a sequence (k counted from 0) is stored at word k, and rd_data shows word rd_addr combinationally.
- R3: With setting N on smp_per_irq, done and irq become 1 in the cycle after the (N+1)-th accepted conversion is clocked in, and not earlier. N ranges from 0 (one sample) to 15 (sixteen samples).
- R4: irq stays 1 until a cycle with irq_clear=1. If a sequence completes in the same cycle as irq_clear, irq stays set.
- R5: done returns to 0 after the first accepted conversion of the next sequence, unless that conversion also completes a sequence.
- R6: In split mode, conversions go to word fill_half*8+k. fill_half starts at 0 and inverts after every completed sequence.
- R7: In split mode, a setting above 7 is treated as 7, so each interrupt comes after 8 conversions and no write leaves the current half.
- R8: While enable=0, conversions are ignored: the memory, done and irq are unchanged. The fill count returns to 0 and fill_half returns to 0.
- R9: In linear mode, fill_half stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module on; when low, restarts the fill position and blocks writes |
| conv_valid | input | 1 | One-cycle strobe: a conversion result is present |
| conv_data | input | 12 | Conversion result |
| smp_per_irq | input | 4 | Setting N; N+1 samples per interrupt |
| split_mode | input | 1 | 1 selects two alternating 8-word halves |
| irq_clear | input | 1 | Clears the interrupt flag |
| rd_addr | input | 4 | Read index 0 to 15 |
| rd_data | output | 12 | Word at rd_addr |
| done | output | 1 | Sequence complete |
| irq | output | 1 | Sticky interrupt flag |
| fill_half | output | 1 | Half currently being written (split mode) |

## Verification
The bench sweeps all sixteen settings in linear mode. A counter that is off by one would raise irq one conversion early or late, or would leave the last word unwritten. In split mode it runs three sequences per setting, including settings above 7. A design that did not clamp the setting would write into the half that software is reading, and one that did not swap halves would overwrite the previous sequence. The bench also sends a clear in the same cycle as a completion, where a design that gave the clear priority would lose an interrupt. Finally, it strobes conversions while the block is disabled, which a leaky design would store or count.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
    parameter int SAMPLE_W  = 12;
    parameter int BUF_WORDS = 16;
    localparam int PTR_W    = $clog2(BUF_WORDS);
    localparam int HALF_W   = BUF_WORDS / 2;

    typedef struct packed {
        logic [PTR_W-1:0] cnt;
        logic             half;
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic irq;
    } flag_state_t;
endpackage

// File: rtl/adcbuf_seq.sv
module adcbuf_seq
    import adcbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             conv_valid,
    input  logic [PTR_W-1:0] smp_cfg,
    input  logic             split_mode,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic             seq_done,
    output logic             half
);
    localparam logic [PTR_W-1:0] HALF_LAST = PTR_W'(HALF_W - 1);

    seq_state_t       st_d, st_q;
    logic [PTR_W-1:0] last_idx;

    always_comb begin
        st_d = st_q;
        if (split_mode) begin
            last_idx = (smp_cfg > HALF_LAST) ? HALF_LAST : smp_cfg;
            wr_addr  = {st_q.half, st_q.cnt[PTR_W-2:0]};
        end else begin
            last_idx = smp_cfg;
            wr_addr  = st_q.cnt;
        end
        wr_en    = enable && conv_valid;
        seq_done = wr_en && (st_q.cnt >= last_idx);

        if (!enable) begin
            st_d.cnt  = '0;
            st_d.half = 1'b0;
        end else begin
            if (wr_en) begin
                if (seq_done) begin
                    st_d.cnt  = '0;
                    st_d.half = split_mode ? ~st_q.half : 1'b0;
                end else begin
                    st_d.cnt  = st_q.cnt + 1'b1;
                end
            end
            if (!split_mode) begin
                st_d.half = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign half = st_q.half;
endmodule

// File: rtl/adcbuf_mem.sv
module adcbuf_mem
    import adcbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [PTR_W-1:0]    wr_addr,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic [PTR_W-1:0]    rd_addr,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] word_q [BUF_WORDS];

    for (genvar w = 0; w < BUF_WORDS; w++) begin : g_word
        logic [SAMPLE_W-1:0] word_d;

        always_comb begin
            word_d = word_q[w];
            if (wr_en && (wr_addr == PTR_W'(w))) begin
                word_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else begin
                word_q[w] <= word_d;
            end
        end
    end

    assign rd_data = word_q[rd_addr];
endmodule

// File: rtl/adcbuf_flags.sv
module adcbuf_flags
    import adcbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic seq_done,
    input  logic irq_clear,
    output logic done,
    output logic irq
);
    flag_state_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (seq_done) begin
            fl_d.done = 1'b1;
        end else if (wr_en) begin
            fl_d.done = 1'b0;
        end
        if (seq_done) begin
            fl_d.irq = 1'b1;
        end else if (irq_clear) begin
            fl_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign done = fl_q.done;
    assign irq  = fl_q.irq;
endmodule

// File: rtl/adc_result_buffer.sv
module adc_result_buffer
    import adcbuf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                conv_valid,
    input  logic [SAMPLE_W-1:0] conv_data,
    input  logic [PTR_W-1:0]    smp_per_irq,
    input  logic                split_mode,
    input  logic                irq_clear,
    input  logic [PTR_W-1:0]    rd_addr,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                done,
    output logic                irq,
    output logic                fill_half
);
    logic             wr_en;
    logic             seq_done;
    logic [PTR_W-1:0] wr_addr;

    adcbuf_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .conv_valid (conv_valid),
        .smp_cfg    (smp_per_irq),
        .split_mode (split_mode),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .seq_done   (seq_done),
        .half       (fill_half)
    );

    adcbuf_mem u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (conv_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    adcbuf_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .seq_done  (seq_done),
        .irq_clear (irq_clear),
        .done      (done),
        .irq       (irq)
    );
endmodule

// File: rtl/adcbuf_checker.sv
module adcbuf_checker
    import adcbuf_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             conv_valid,
    input logic             split_mode,
    input logic             irq_clear,
    input logic             done,
    input logic             irq,
    input logic             fill_half,
    input logic             wr_en,
    input logic             seq_done,
    input logic [PTR_W-1:0] wr_addr
);
    p_irq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !irq_clear |=> irq);

    p_irq_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done && irq_clear |=> irq);

    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear && !seq_done |=> !irq);

    p_done_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(enable && conv_valid));

    p_done_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done && wr_en && !seq_done |=> !done);

    p_half_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        enable && split_mode && seq_done |=> fill_half != $past(fill_half));

    p_half_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && split_mode |-> wr_addr[PTR_W-1] == fill_half);

    p_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fill_half && $stable(irq) && $stable(done));

    p_linear_half_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !split_mode |=> !fill_half);
endmodule

bind adc_result_buffer adcbuf_checker u_chk (.*);

// File: tb/tb_adc_result_buffer.sv
`timescale 1ns/1ps
module tb_adc_result_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        conv_valid = 1'b0;
    logic [11:0] conv_data = '0;
    logic [3:0]  smp_per_irq = '0;
    logic        split_mode = 1'b0;
    logic        irq_clear = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [11:0] rd_data;
    logic        done, irq, fill_half;

    int checks = 0;
    int fails  = 0;
    logic [11:0] exp_mem [16];

    always #4 clk = ~clk;

    adc_result_buffer dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .conv_valid(conv_valid),
        .conv_data(conv_data), .smp_per_irq(smp_per_irq), .split_mode(split_mode),
        .irq_clear(irq_clear), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .irq(irq), .fill_half(fill_half)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic conv(input logic [11:0] d, input logic clr);
        conv_valid = 1'b1;
        conv_data  = d;
        irq_clear  = clr;
        step();
        conv_valid = 1'b0;
        irq_clear  = 1'b0;
    endtask

    task automatic clear_irq();
        irq_clear = 1'b1;
        step();
        irq_clear = 1'b0;
    endtask

    task automatic restart();
        enable = 1'b0;
        step();
        enable = 1'b1;
    endtask

    task automatic check_mem(input string tag);
        for (int a = 0; a < 16; a++) begin
            rd_addr = 4'(a);
            #1;
            chk(rd_data, exp_mem[a], tag);
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int a = 0; a < 16; a++) exp_mem[a] = '0;
        step(); step();
        rst_n = 1'b1;
        step();
        // R1
        chk(done, 0, "R1 done");
        chk(irq, 0, "R1 irq");
        chk(fill_half, 0, "R1 fill_half");
        check_mem("R1 memory");

        // Linear sweep over every setting: R2, R3, R5, R9
        split_mode = 1'b0;
        for (int n = 0; n < 16; n++) begin
            smp_per_irq = 4'(n);
            restart();
            clear_irq();
            for (int i = 0; i <= n; i++) begin
                logic [11:0] d;
                d = 12'((n * 37 + i * 5 + 1) ^ 12'h5A3);
                exp_mem[i] = d;
                conv(d, 1'b0);
                chk(irq, (i == n) ? 1 : 0, "R3 irq after conversion");
                chk(done, (i == n) ? 1 : 0, "R3/R5 done after conversion");
                chk(fill_half, 0, "R9 fill_half linear");
            end
            check_mem("R2 linear word");
            step(); step(); step();
            chk(irq, 1, "R4 irq sticky");
        end

        // Clear in the same cycle as completion: R4
        smp_per_irq = 4'd1;
        restart();
        conv(12'h111, 1'b0);
        conv(12'h222, 1'b1);
        exp_mem[0] = 12'h111;
        exp_mem[1] = 12'h222;
        chk(irq, 1, "R4 set beats clear");
        clear_irq();
        chk(irq, 0, "R4 clear");

        // Split mode, settings at, below and above the half size: R6, R7
        split_mode = 1'b1;
        for (int t = 0; t < 4; t++) begin
            int n, eff;
            n = (t == 0) ? 7 : (t == 1) ? 3 : (t == 2) ? 15 : 10;
            eff = (n > 7) ? 8 : n + 1;
            smp_per_irq = 4'(n);
            restart();
            for (int s = 0; s < 3; s++) begin
                int h;
                h = s % 2;
                clear_irq();
                chk(fill_half, h, "R6 fill_half before sequence");
                for (int i = 0; i < eff; i++) begin
                    logic [11:0] d;
                    d = 12'((t * 211 + s * 53 + i * 7 + 3) ^ 12'hC3C);
                    exp_mem[h * 8 + i] = d;
                    conv(d, 1'b0);
                    chk(irq, (i == eff - 1) ? 1 : 0, "R7 irq count in split mode");
                end
                chk(fill_half, 1 - h, "R6 fill_half swapped");
                check_mem("R6 split word");
            end
        end

        // Disabled block ignores conversions and restarts: R8
        smp_per_irq = 4'd0;
        clear_irq();
        enable = 1'b0;
        for (int i = 0; i < 4; i++) conv(12'hABC, 1'b0);
        chk(irq, 0, "R8 irq unchanged while disabled");
        chk(fill_half, 0, "R8 fill_half restarted");
        check_mem("R8 memory unchanged while disabled");
        enable = 1'b1;
        conv(12'h0F1, 1'b0);
        exp_mem[0] = 12'h0F1;
        chk(fill_half, 1, "R8 restart then one-sample sequence swaps");
        check_mem("R8 first write lands at word 0");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule